// File: doc/BRIEF.md
# Deferred Completion Write-Back Sequencer

This block decides the order in which transmit descriptors are reported as finished, and where the ring head pointer sits. The fetch side hands it processed descriptors in ring order. Each one carries its command byte and its ring index. Most descriptors retire as soon as they reach the front of a small in-order queue. A descriptor that asks for a status write-back gets a write-back request with descriptor-done set.

A descriptor may instead ask to be reported only once its packet has actually left on the wire. Such a descriptor carries the report-sent flag, and the flag counts only when end-of-packet is also set. It then blocks the queue: no later write-back is issued and the head pointer does not move. This lasts until the MAC side signals that the packet was sent, or that it failed with excess collisions or a late collision. The held descriptor is then written back first, with the matching error bits, and the queued descriptors behind it follow in order. New descriptors keep being accepted during the stall until the queue is full.

A two-state machine controls the queue. In `SEQ_FLOW` the head entry retires one per cycle. The transition FLOW->HOLD is taken when the head entry has report-sent and end-of-packet set. In `SEQ_HOLD` the head entry is parked. The transition HOLD->FLOW is taken on any MAC outcome pulse, and in that same cycle the held entry is retired.

Top module: `txc_wb_seq`

## Requirements
- R1: After reset, `head_ptr` is 0, `wb_valid` is 0, `wb_status` is 0 and `ent_ready` is 1.
- R2: In the command byte, bit 0 is end-of-packet, bit 3 is report-status and bit 4 is report-sent; the other bits are ignored. A write-back request is issued for a retired descriptor only if bit 3 or bit 4 is set.
- R3: Descriptors that do not hold retire in arrival order, one per cycle. An entry accepted at clock edge N while the queue is empty and the state is `SEQ_FLOW` retires at edge N+1, and its write-back (if any) is visible after that edge.
- R4: `head_ptr` advances by exactly one for every retired descriptor and wraps from RING_SIZE-1 to 0. `wb_idx` carries the ring index of the descriptor being written back.
- R5: A head entry with bit 4 and bit 0 both set causes a hold. Until a MAC outcome arrives, no write-back is issued and `head_ptr` does not change.
- R6: Bit 4 without bit 0 does not hold. The descriptor retires at once and is written back with descriptor-done only.
- R7: Entries are accepted during a hold. `ent_ready` is 0 exactly while DEPTH entries are queued, and an offered entry is not taken while `ent_ready` is 0.
- R8: In `wb_status`, bit 0 is descriptor-done (always 1 in a request), bit 1 is excess-collisions and bit 2 is late-collision. bit 3 is 0. A held descriptor ending with `mac_sent` reports 4'b0001, with `mac_fail_ec` 4'b0011, and with `mac_fail_lc` 4'b0101.
- R9: MAC outcome pulses while in `SEQ_FLOW` have no effect on write-backs or on `head_ptr`.
- R10: When a hold ends, the held descriptor is written back first, followed by the descriptors queued behind it in their arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | 1 | A processed descriptor is offered |
| ent_ready | output | 1 | Queue can take a descriptor |
| ent_cmd | input | 8 | Descriptor command byte |
| ent_idx | input | IDX_W | Ring index of the descriptor |
| mac_sent | input | 1 | Held packet left the wire successfully (pulse) |
| mac_fail_ec | input | 1 | Held packet failed on excess collisions (pulse) |
| mac_fail_lc | input | 1 | Held packet failed on late collision (pulse) |
| wb_valid | output | 1 | Write-back request this cycle |
| wb_idx | output | IDX_W | Ring index to write back |
| wb_status | output | 4 | Status nibble to write |
| head_ptr | output | IDX_W | Ring head pointer |

## Verification
The first pattern is a sweep over every combination of the low five command bits, sent back to back, excluding the combination that holds. It separates the write-back decision from the retire decision, and it shows that report-sent without end-of-packet is not a hold. The head pointer wraps several times during this sweep. The second pattern fills the queue behind a held descriptor and then ends the hold with each of the three MAC outcomes. This tells stall and ordering faults apart from status-encoding faults. The last pattern sends outcome pulses with nothing held, which exposes a sequencer that reacts to MAC events outside a hold.

// File: rtl/txc_pkg.sv
package txc_pkg;
    // command byte bit positions decoded by the sequencer
    localparam int CMD_EOP = 0;
    localparam int CMD_RS  = 3;
    localparam int CMD_RPS = 4;

    // status nibble bit positions
    localparam int STS_DD = 0;
    localparam int STS_EC = 1;
    localparam int STS_LC = 2;
    localparam int STS_W  = 4;

    typedef enum logic [0:0] {
        SEQ_FLOW = 1'b0,
        SEQ_HOLD = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic rps;
        logic rs;
        logic eop;
    } cmd_flags_t;
endpackage

// File: rtl/txc_fifo.sv
module txc_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [LVL_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    assign rdata = mem[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == LVL_W'(DEPTH));
    assign level = cnt;
endmodule

// File: rtl/txc_head_ctr.sv
module txc_head_ctr #(
    parameter int RING_SIZE = 8,
    localparam int IDX_W = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] head
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
        end else if (advance) begin
            head <= (head == IDX_W'(RING_SIZE - 1)) ? '0 : head + 1'b1;
        end
    end
endmodule

// File: rtl/txc_ctrl.sv
module txc_ctrl
    import txc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_vld,
    input  cmd_flags_t        head_flags,
    input  logic [IDX_W-1:0]  head_idx,
    input  logic              mac_sent,
    input  logic              mac_fail_ec,
    input  logic              mac_fail_lc,
    output logic              pop,
    output seq_state_e        state,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [STS_W-1:0]  wb_status
);
    seq_state_e       nxt;
    logic             wb_nxt;
    logic [STS_W-1:0] sts_nxt;
    logic             mac_any;

    assign mac_any = mac_sent | mac_fail_ec | mac_fail_lc;

    // next-state and retire decision
    always_comb begin
        nxt     = state;
        pop     = 1'b0;
        wb_nxt  = 1'b0;
        sts_nxt = '0;
        unique case (state)
            SEQ_FLOW: begin
                if (head_vld) begin
                    if (head_flags.rps && head_flags.eop) begin
                        nxt = SEQ_HOLD;
                    end else begin
                        pop             = 1'b1;
                        wb_nxt          = head_flags.rs | head_flags.rps;
                        sts_nxt[STS_DD] = 1'b1;
                    end
                end
            end
            SEQ_HOLD: begin
                if (mac_any) begin
                    pop             = 1'b1;
                    wb_nxt          = 1'b1;
                    sts_nxt[STS_DD] = 1'b1;
                    sts_nxt[STS_EC] = mac_fail_ec;
                    sts_nxt[STS_LC] = mac_fail_lc;
                    nxt             = SEQ_FLOW;
                end
            end
            default: nxt = SEQ_FLOW;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_FLOW;
        end else begin
            state <= nxt;
        end
    end

    // registered write-back outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid  <= 1'b0;
            wb_idx    <= '0;
            wb_status <= '0;
        end else begin
            wb_valid  <= wb_nxt;
            wb_status <= wb_nxt ? sts_nxt : '0;
            if (wb_nxt) begin
                wb_idx <= head_idx;
            end
        end
    end
endmodule

// File: rtl/txc_wb_seq.sv
module txc_wb_seq
    import txc_pkg::*;
#(
    parameter int RING_SIZE = 8,
    parameter int DEPTH     = 4,
    localparam int IDX_W = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1,
    localparam int ENT_W = 3 + IDX_W,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ent_valid,
    output logic             ent_ready,
    input  logic [7:0]       ent_cmd,
    input  logic [IDX_W-1:0] ent_idx,
    input  logic             mac_sent,
    input  logic             mac_fail_ec,
    input  logic             mac_fail_lc,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_idx,
    output logic [3:0]       wb_status,
    output logic [IDX_W-1:0] head_ptr
);
    cmd_flags_t       in_flags;
    cmd_flags_t       hd_flags;
    logic [ENT_W-1:0] q_wdata;
    logic [ENT_W-1:0] q_rdata;
    logic             q_empty;
    logic             q_full;
    logic [LVL_W-1:0] q_level;
    logic             q_push;
    logic             q_pop;
    seq_state_e       seq_state;
    logic             in_hold;
    logic             unused_cmd_bits;

    assign unused_cmd_bits = ^{ent_cmd[7:5], ent_cmd[2:1]};

    assign in_flags.rps = ent_cmd[CMD_RPS];
    assign in_flags.rs  = ent_cmd[CMD_RS];
    assign in_flags.eop = ent_cmd[CMD_EOP];
    assign q_wdata      = {in_flags, ent_idx};
    assign ent_ready    = !q_full;
    assign q_push       = ent_valid && ent_ready;
    assign hd_flags     = q_rdata[ENT_W-1 -: 3];
    assign in_hold      = (seq_state == SEQ_HOLD);

    txc_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .wdata (q_wdata),
        .pop   (q_pop),
        .rdata (q_rdata),
        .empty (q_empty),
        .full  (q_full),
        .level (q_level)
    );

    txc_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_vld    (!q_empty),
        .head_flags  (hd_flags),
        .head_idx    (q_rdata[IDX_W-1:0]),
        .mac_sent    (mac_sent),
        .mac_fail_ec (mac_fail_ec),
        .mac_fail_lc (mac_fail_lc),
        .pop         (q_pop),
        .state       (seq_state),
        .wb_valid    (wb_valid),
        .wb_idx      (wb_idx),
        .wb_status   (wb_status)
    );

    txc_head_ctr #(.RING_SIZE(RING_SIZE)) u_head (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (q_pop),
        .head    (head_ptr)
    );
endmodule

// File: rtl/txc_wb_seq_chk.sv
module txc_wb_seq_chk #(
    parameter int RING_SIZE = 8,
    parameter int DEPTH     = 4,
    localparam int IDX_W = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ent_ready,
    input logic             mac_sent,
    input logic             mac_fail_ec,
    input logic             mac_fail_lc,
    input logic             wb_valid,
    input logic [3:0]       wb_status,
    input logic [IDX_W-1:0] head_ptr,
    input logic             in_hold,
    input logic [LVL_W-1:0] q_level
);
    logic mac_any;
    assign mac_any = mac_sent | mac_fail_ec | mac_fail_lc;

    p_hold_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && !mac_any) |=> !wb_valid);

    p_hold_head_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && !mac_any) |=> $stable(head_ptr));

    p_head_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(head_ptr) |-> head_ptr == (($past(head_ptr) == IDX_W'(RING_SIZE - 1))
                                            ? '0 : $past(head_ptr) + 1'b1));

    p_wb_dd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_status[0] && !wb_status[3]));

    p_quiet_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |-> (wb_status == 4'd0));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= LVL_W'(DEPTH));

    p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_level == LVL_W'(DEPTH)) |-> !ent_ready);
endmodule

bind txc_wb_seq txc_wb_seq_chk #(.RING_SIZE(RING_SIZE), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ent_ready   (ent_ready),
    .mac_sent    (mac_sent),
    .mac_fail_ec (mac_fail_ec),
    .mac_fail_lc (mac_fail_lc),
    .wb_valid    (wb_valid),
    .wb_status   (wb_status),
    .head_ptr    (head_ptr),
    .in_hold     (in_hold),
    .q_level     (q_level)
);

// File: tb/txc_wb_seq_tb.sv
module txc_wb_seq_tb;
    localparam int RING = 8;
    localparam int DEP  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ent_valid = 1'b0;
    logic       ent_ready;
    logic [7:0] ent_cmd = 8'h00;
    logic [2:0] ent_idx = 3'd0;
    logic       mac_sent = 1'b0;
    logic       mac_fail_ec = 1'b0;
    logic       mac_fail_lc = 1'b0;
    logic       wb_valid;
    logic [2:0] wb_idx;
    logic [3:0] wb_status;
    logic [2:0] head_ptr;

    int checks = 0;
    int errors = 0;
    int log_n = 0;
    int log_idx [256];
    int log_st  [256];
    int exp_idx [64];
    int exp_st  [64];
    int retired = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    txc_wb_seq #(.RING_SIZE(RING), .DEPTH(DEP)) u_dut (
        .clk, .rst_n, .ent_valid, .ent_ready, .ent_cmd, .ent_idx,
        .mac_sent, .mac_fail_ec, .mac_fail_lc,
        .wb_valid, .wb_idx, .wb_status, .head_ptr
    );

    always @(negedge clk) begin
        if (rst_n && wb_valid && log_n < 256) begin
            log_idx[log_n] = int'(wb_idx);
            log_st[log_n]  = int'(wb_status);
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] c, input logic [2:0] i);
        ent_cmd   = c;
        ent_idx   = i;
        ent_valid = 1'b1;
        @(posedge clk);
        while (!ent_ready) @(posedge clk);
        @(negedge clk);
        ent_valid = 1'b0;
        retired++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        int n_exp;
        int h0;
        idle(3);
        // R1 reset state
        chk(head_ptr == 3'd0, "R1 head", int'(head_ptr), 0);
        chk(wb_valid == 1'b0, "R1 wb_valid", int'(wb_valid), 0);
        chk(wb_status == 4'd0, "R1 wb_status", int'(wb_status), 0);
        chk(ent_ready == 1'b1, "R1 ready", int'(ent_ready), 1);
        rst_n = 1'b1;
        idle(2);

        // R3 single-entry latency
        base = log_n;
        push(8'h08, 3'd5);
        chk(wb_valid == 1'b0, "R3 latency early", int'(wb_valid), 0);
        @(negedge clk);
        chk(wb_valid == 1'b1, "R3 latency", int'(wb_valid), 1);
        chk(wb_idx == 3'd5, "R4 idx", int'(wb_idx), 5);
        idle(3);

        // R2 R6 R3 R4 sweep of low command bits, back to back
        base = log_n;
        n_exp = 0;
        for (int c = 0; c < 32; c++) begin
            if (!(c[4] && c[0])) begin
                int ix;
                ix = retired % RING;
                if (c[3] || c[4]) begin
                    exp_idx[n_exp] = ix;
                    exp_st[n_exp]  = 1;
                    n_exp++;
                end
                push(8'(c) | 8'hE6 & 8'(c * 37), 3'(ix));
            end
        end
        idle(8);
        chk(log_n - base == n_exp, "R2 writeback count", log_n - base, n_exp);
        for (int k = 0; k < n_exp; k++) begin
            chk(log_idx[base + k] == exp_idx[k], "R3 order", log_idx[base + k], exp_idx[k]);
            chk(log_st[base + k] == exp_st[k], "R6 status", log_st[base + k], exp_st[k]);
        end
        chk(int'(head_ptr) == retired % RING, "R4 head wrap", int'(head_ptr), retired % RING);

        // R9 MAC pulses with nothing held
        base = log_n;
        h0 = int'(head_ptr);
        mac_sent = 1'b1; @(negedge clk); mac_sent = 1'b0;
        mac_fail_ec = 1'b1; mac_fail_lc = 1'b1; @(negedge clk);
        mac_fail_ec = 1'b0; mac_fail_lc = 1'b0;
        idle(3);
        chk(log_n == base, "R9 no writeback", log_n - base, 0);
        chk(int'(head_ptr) == h0, "R9 head", int'(head_ptr), h0);

        // R5 R7 R8 R10 holds ended by each outcome
        for (int o = 0; o < 3; o++) begin
            int held;
            int es;
            base = log_n;
            h0 = int'(head_ptr);
            held = retired % RING;
            push(8'h19, 3'(held));
            for (int k = 0; k < 3; k++) push(8'h08, 3'(retired % RING));
            chk(ent_ready == 1'b0, "R7 full", int'(ent_ready), 0);
            ent_cmd = 8'h08; ent_idx = 3'd7; ent_valid = 1'b1;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (wb_valid || int'(head_ptr) != h0) begin
                    chk(1'b0, "R5 stall", int'(head_ptr), h0);
                end
            end
            ent_valid = 1'b0;
            chk(log_n == base, "R5 no writeback", log_n - base, 0);
            chk(int'(head_ptr) == h0, "R5 head held", int'(head_ptr), h0);
            unique case (o)
                0: begin mac_sent = 1'b1; es = 1; end
                1: begin mac_fail_ec = 1'b1; es = 3; end
                default: begin mac_fail_lc = 1'b1; es = 5; end
            endcase
            @(negedge clk);
            mac_sent = 1'b0; mac_fail_ec = 1'b0; mac_fail_lc = 1'b0;
            idle(6);
            chk(log_n - base == 4, "R7 no extra accept", log_n - base, 4);
            chk(log_idx[base] == held, "R10 held first", log_idx[base], held);
            chk(log_st[base] == es, "R8 status", log_st[base], es);
            for (int k = 1; k < 4; k++) begin
                int ei;
                ei = (held + k) % RING;
                chk(log_idx[base + k] == ei, "R10 order", log_idx[base + k], ei);
                chk(log_st[base + k] == 1, "R8 dd only", log_st[base + k], 1);
            end
            chk(int'(head_ptr) == (h0 + 4) % RING, "R4 head after hold",
                int'(head_ptr), (h0 + 4) % RING);
        end

        finish_run();
    end
endmodule